// File: doc/BRIEF.md
# Oversampled Serial Receiver with Activity Flag

This block receives asynchronous serial frames from a single input line. A tick input is high for one clock at 16 times the bit rate, and the receiver looks at the line only on clocks where the tick is high. A frame is one start bit, then 8 or 9 data bits with the least significant bit first, then one stop bit. The line can be read in two ways. In level mode each bit is decided by a majority vote of three samples near the middle of the bit. In pulse mode a bit is a 0 when a short pulse appears anywhere in its window. Either mode can have its polarity inverted.

The receiver raises an activity flag as soon as it sees the first low decoded sample while it is hunting for a start bit. The flag stays up until the line has been idle for a whole frame. Each received frame comes out on the data port with a one-clock valid strobe. A framing-error flag goes with the strobe when the stop bit was read as 0. A separate one-clock pulse marks the point where an idle stretch is detected.

Top module: `uart_rx_act`

## Requirements
- R1: After reset, `rx_data_o` is 0, all flags and strobes are 0, and the receiver is hunting for a start bit.
- R2: In level mode, the decoded value is `rx_line_i` XOR `inv_pol_i`. A decoded 1 is a logic 1, so with `inv_pol_i`=0 a high line is a 1.
- R3: In pulse mode with `inv_pol_i`=0, a bit is 0 when the line is high for at least one tick inside the 16-tick bit window, and 1 when the line stays low for the whole window. With `inv_pol_i`=1, a low pulse marks a 0 and a line that stays high marks a 1.
- R4: The tick on which the start bit is detected is phase 1. In level mode, each bit is the majority of its decoded samples at phases 8, 9 and 10 of its 16-tick window. Samples at other phases have no effect on the bit.
- R5: While hunting, a tick with a decoded 0 (phase RT1) sets `rx_active_o`. The flag is visible from the next clock.
- R6: Data bits arrive least significant bit first. There are 9 of them when `nine_bit_i`=1 and 8 when it is 0. In 8-bit mode, `rx_data_o[8]` is 0. `rx_valid_o` is high for exactly one clock: the clock after the tick that ends the stop-bit window.
- R7: When the stop bit decodes as 0, `frame_err_o` is high in the same clock as `rx_valid_o`, and the data is still delivered.
- R8: When the start bit decodes as 1 (a false start), the receiver gives no strobe and goes back to hunting.
- R9: While hunting, when the number of consecutive decoded-1 ticks reaches 16 times the frame length (160 ticks for 8-bit frames, 176 for 9-bit frames), `idle_o` pulses for one clock. In that same clock `rx_active_o` clears. The pulse fires only once for each unbroken idle stretch.
- R10: Clocks with `os_tick_i` low advance nothing. On the next clock there is no strobe, no idle pulse, and no change to the activity flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line_i | input | 1 | Raw serial line |
| os_tick_i | input | 1 | Oversampling tick, 16 per bit |
| nine_bit_i | input | 1 | 1: 9 data bits, 0: 8 data bits |
| irda_en_i | input | 1 | 1: pulse decoding, 0: level decoding |
| inv_pol_i | input | 1 | Inverts line polarity |
| rx_data_o | output | 9 | Last received data |
| rx_valid_o | output | 1 | One-clock strobe for a new frame |
| frame_err_o | output | 1 | Stop bit was 0; accompanies the strobe |
| idle_o | output | 1 | One-clock idle-detected pulse |
| rx_active_o | output | 1 | Reception in progress |

## Verification
Every output is registered, so each result appears on the clock after the tick that causes it. The activity flag rises one clock after the RT1 tick. The strobe rises one clock after the tick that ends the stop window. The idle pulse rises one clock after the 160th or 176th idle tick. The bench uses a queue-based model that advances on the same rising edges. It compares all five outputs at the falling edge of every clock, so none of these one-clock pulses can fall between samples. After each scenario, frame and pulse counts confirm what that scenario was meant to show.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int OVS_TICKS = 16;
    localparam int DATA_MAX  = 9;

    typedef enum logic [0:0] {
        RXS_HUNT  = 1'b0,
        RXS_FRAME = 1'b1
    } rx_state_e;
endpackage

// File: rtl/rx_line_decode.sv
module rx_line_decode (
    input  logic line_i,
    input  logic irda_i,
    input  logic inv_i,
    output logic bit_o
);
    logic lvl;
    // Polarity is applied first. Pulse mode then reads a pulse as a logic 0.
    always_comb begin
        lvl   = line_i ^ inv_i;
        bit_o = irda_i ? ~lvl : lvl;
    end
endmodule

// File: rtl/rx_bit_judge.sv
module rx_bit_judge #(
    parameter int OVS  = 16,
    parameter int IDXW = 5
) (
    input  logic            irda_i,
    input  logic [IDXW-1:0] idx_i,
    input  logic            smp_i,
    input  logic [1:0]      votes_i,
    input  logic            acc_i,
    output logic [1:0]      votes_o,
    output logic            acc_o,
    output logic            bit_o
);
    localparam int VA = OVS / 2;
    localparam int VB = VA + 1;
    localparam int VC = VA + 2;

    logic in_vote;
    always_comb begin
        in_vote = (int'(idx_i) == VA) || (int'(idx_i) == VB) || (int'(idx_i) == VC);
        votes_o = votes_i + {1'b0, (in_vote && smp_i)};
        acc_o   = acc_i & smp_i;
        bit_o   = irda_i ? acc_o : (votes_o >= 2'd2);
    end
endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic          smp_i,
    input  logic [CW-1:0] limit_i,
    output logic          fire_o,
    output logic          idle_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } idle_regs_t;

    idle_regs_t q, n;

    always_comb begin
        n       = q;
        n.pulse = 1'b0;
        fire_o  = 1'b0;
        if (!run_i) begin
            n.cnt = '0;
        end else if (tick_i) begin
            if (!smp_i) begin
                n.cnt = '0;
            end else if (q.cnt < limit_i) begin
                n.cnt = q.cnt + 1'b1;
                if (n.cnt == limit_i) begin
                    fire_o  = 1'b1;
                    n.pulse = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign idle_o = q.pulse;
endmodule

// File: rtl/uart_rx_act.sv
module uart_rx_act
    import uart_rx_pkg::*;
#(
    parameter int OVS  = OVS_TICKS,
    parameter int DMAX = DATA_MAX
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_line_i,
    input  logic            os_tick_i,
    input  logic            nine_bit_i,
    input  logic            irda_en_i,
    input  logic            inv_pol_i,
    output logic [DMAX-1:0] rx_data_o,
    output logic            rx_valid_o,
    output logic            frame_err_o,
    output logic            idle_o,
    output logic            rx_active_o
);
    localparam int PHW  = $clog2(OVS);
    localparam int IDXW = PHW + 1;
    localparam int BW   = $clog2(DMAX + 2);
    localparam int CW   = $clog2(OVS * (DMAX + 2) + 1);
    localparam logic [BW-1:0] STOP_LONG  = BW'(DMAX + 1);
    localparam logic [BW-1:0] STOP_SHORT = BW'(DMAX);
    localparam logic [CW-1:0] LIM_LONG   = CW'(OVS * (DMAX + 2));
    localparam logic [CW-1:0] LIM_SHORT  = CW'(OVS * (DMAX + 1));

    typedef struct packed {
        rx_state_e       st;
        logic [PHW-1:0]  ph;
        logic [BW-1:0]   bidx;
        logic [1:0]      votes;
        logic            acc;
        logic [DMAX-1:0] sh;
        logic [DMAX-1:0] data;
        logic            valid;
        logic            ferr;
        logic            active;
    } rx_regs_t;

    rx_regs_t q, n;

    logic            smp;
    logic [IDXW-1:0] idx;
    logic [1:0]      j_votes;
    logic            j_acc;
    logic            j_bit;
    logic            idle_fire;
    logic [BW-1:0]   stop_idx;
    logic [CW-1:0]   idle_lim;

    assign idx      = {1'b0, q.ph} + 1'b1;
    assign stop_idx = nine_bit_i ? STOP_LONG : STOP_SHORT;
    assign idle_lim = nine_bit_i ? LIM_LONG : LIM_SHORT;

    rx_line_decode u_dec (
        .line_i (rx_line_i),
        .irda_i (irda_en_i),
        .inv_i  (inv_pol_i),
        .bit_o  (smp)
    );

    rx_bit_judge #(.OVS(OVS), .IDXW(IDXW)) u_judge (
        .irda_i  (irda_en_i),
        .idx_i   (idx),
        .smp_i   (smp),
        .votes_i (q.votes),
        .acc_i   (q.acc),
        .votes_o (j_votes),
        .acc_o   (j_acc),
        .bit_o   (j_bit)
    );

    rx_idle_watch #(.CW(CW)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (os_tick_i),
        .run_i   (q.st == RXS_HUNT),
        .smp_i   (smp),
        .limit_i (idle_lim),
        .fire_o  (idle_fire),
        .idle_o  (idle_o)
    );

    always_comb begin
        n       = q;
        n.valid = 1'b0;
        n.ferr  = 1'b0;
        if (os_tick_i) begin
            unique case (q.st)
                RXS_HUNT: begin
                    if (!smp) begin
                        // RT1: the first low sample is phase 1 of the start bit
                        n.active = 1'b1;
                        n.st     = RXS_FRAME;
                        n.ph     = PHW'(1);
                        n.bidx   = '0;
                        n.votes  = '0;
                        n.acc    = 1'b0;
                    end else if (idle_fire) begin
                        n.active = 1'b0;
                    end
                end
                RXS_FRAME: begin
                    n.votes = j_votes;
                    n.acc   = j_acc;
                    n.ph    = q.ph + 1'b1;
                    if (int'(idx) == OVS) begin
                        n.ph    = '0;
                        n.votes = '0;
                        n.acc   = 1'b1;
                        if (q.bidx == '0) begin
                            if (j_bit) n.st = RXS_HUNT;
                            else       n.bidx = BW'(1);
                        end else if (q.bidx == stop_idx) begin
                            n.data  = nine_bit_i ? q.sh : {1'b0, q.sh[DMAX-1:1]};
                            n.valid = 1'b1;
                            n.ferr  = ~j_bit;
                            n.st    = RXS_HUNT;
                            n.bidx  = '0;
                        end else begin
                            n.sh   = {j_bit, q.sh[DMAX-1:1]};
                            n.bidx = q.bidx + 1'b1;
                        end
                    end
                end
                default: n.st = RXS_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= RXS_HUNT;
        end else begin
            q <= n;
        end
    end

    assign rx_data_o   = q.data;
    assign rx_valid_o  = q.valid;
    assign frame_err_o = q.ferr;
    assign rx_active_o = q.active;
endmodule

// File: rtl/uart_rx_act_chk.sv
module uart_rx_act_chk #(
    parameter int DMAX = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            os_tick_i,
    input logic            nine_bit_i,
    input logic [DMAX-1:0] rx_data_o,
    input logic            rx_valid_o,
    input logic            frame_err_o,
    input logic            idle_o,
    input logic            rx_active_o
);
    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R6
    short_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && !nine_bit_i) |-> (rx_data_o[DMAX-1] == 1'b0));

    // R7
    ferr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> rx_valid_o);

    // R9
    idle_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !rx_active_o);

    // R5
    active_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active_o) |-> $past(os_tick_i));

    // R10
    no_tick_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !os_tick_i |=> (!rx_valid_o && !idle_o && $stable(rx_active_o)));
endmodule

bind uart_rx_act uart_rx_act_chk #(.DMAX(DMAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .os_tick_i   (os_tick_i),
    .nine_bit_i  (nine_bit_i),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o),
    .frame_err_o (frame_err_o),
    .idle_o      (idle_o),
    .rx_active_o (rx_active_o)
);

// File: tb/uart_rx_act_test.sv
module uart_rx_act_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line = 1'b1;
    logic       tick = 1'b0;
    logic       nine = 1'b0;
    logic       irda = 1'b0;
    logic       inv  = 1'b0;
    logic [8:0] data;
    logic       valid, ferr, idle, active;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_act uut (
        .clk(clk), .rst_n(rst_n), .rx_line_i(line), .os_tick_i(tick),
        .nine_bit_i(nine), .irda_en_i(irda), .inv_pol_i(inv),
        .rx_data_o(data), .rx_valid_o(valid), .frame_err_o(ferr),
        .idle_o(idle), .rx_active_o(active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   m_hunt = 1;
    bit   m_q[$];
    int   m_nbit = 0;
    int   m_bits[$];
    int   m_idle = 0;
    bit   m_act = 0;
    int   e_data = 0;
    bit   e_valid = 0, e_ferr = 0, e_idle = 0;

    always @(posedge clk) begin
        bit s;
        int lim, nd, bv, v;
        e_valid = 0; e_ferr = 0; e_idle = 0;
        if (!rst_n) begin
            m_hunt = 1; m_q.delete(); m_bits.delete(); m_idle = 0; m_act = 0; e_data = 0;
        end else if (tick) begin
            s   = irda ? ~(line ^ inv) : (line ^ inv);
            nd  = nine ? 9 : 8;
            lim = (nd + 2) * 16;
            if (m_hunt != 0) begin
                if (!s) begin
                    m_act = 1; m_hunt = 0; m_q.delete(); m_q.push_back(s);
                    m_bits.delete(); m_idle = 0;
                end else if (m_idle < lim) begin
                    m_idle++;
                    if (m_idle == lim) begin e_idle = 1; m_act = 0; end
                end
            end else begin
                m_q.push_back(s);
                if (m_q.size() == 16) begin
                    if (irda) begin
                        bv = 1;
                        foreach (m_q[k]) if (!m_q[k]) bv = 0;
                    end else begin
                        bv = (int'(m_q[7]) + int'(m_q[8]) + int'(m_q[9])) >= 2 ? 1 : 0;
                    end
                    m_q.delete();
                    if (m_bits.size() == 0 && bv == 1) begin
                        m_hunt = 1; m_idle = 0;
                    end else begin
                        m_bits.push_back(bv);
                        if (m_bits.size() == nd + 2) begin
                            v = 0;
                            for (int k = 1; k <= nd; k++) v |= m_bits[k] << (k - 1);
                            e_data = v; e_valid = 1; e_ferr = (bv == 0);
                            m_hunt = 1; m_idle = 0;
                        end
                    end
                end
            end
        end
    end

    // ---------------- per-clock comparison and monitors ----------------
    int   n_valid = 0, n_idle = 0;
    int   last_data = 0;
    bit   last_ferr = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(valid == e_valid, "R6 valid", valid, e_valid);
            chk(!valid || data == e_data[8:0], "R6 data", data, e_data);
            chk(ferr == e_ferr, "R7 ferr", ferr, e_ferr);
            chk(idle == e_idle, "R9 idle", idle, e_idle);
            chk(active == m_act, "R5 active", active, m_act);
            if (valid) begin n_valid++; last_data = data; last_ferr = ferr; end
            if (idle) n_idle++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick_raw(input bit raw);
        @(negedge clk); line = raw; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    // flip: decoded-level errors per tick in level mode; pw: pulse width in pulse mode
    task automatic send_bit(input bit b, input logic [15:0] flip, input int pw);
        for (int k = 0; k < 16; k++) begin
            if (irda) tick_raw(((!b) && k >= 6 && k < 6 + pw) ^ inv);
            else      tick_raw((b ^ flip[k]) ^ inv);
        end
    endtask

    task automatic send_idle(input int nb);
        for (int k = 0; k < nb; k++) send_bit(1'b1, 16'h0, 3);
    endtask

    task automatic send_frame(input int d, input bit stopb, input int pw);
        int nd;
        nd = nine ? 9 : 8;
        send_bit(1'b0, 16'h0, pw);
        for (int k = 0; k < nd; k++) send_bit(d[k], 16'h0, pw);
        send_bit(stopb, 16'h0, pw);
        send_idle(2);
    endtask

    task automatic set_mode(input bit ir, input bit iv, input bit nb);
        @(negedge clk);
        irda = ir; inv = iv; nine = nb;
        line = ir ? iv : ~iv;
    endtask

    initial begin
        int nv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(data == 0 && !valid && !ferr && !idle && !active, "R1 reset", {data, valid, ferr, idle, active}, 0);

        // R9: idle from reset, 8-bit limit 160 ticks
        send_idle(11);
        chk(n_idle == 1, "R9 idle count", n_idle, 1);

        // R2 R6: level mode, normal polarity
        nv = n_valid;
        send_frame(9'h0A5, 1'b1, 3);
        chk(n_valid == nv + 1 && last_data == 9'h0A5 && !last_ferr, "R6 frame A5", last_data, 9'h0A5);
        send_frame(9'h03C, 1'b1, 3);
        chk(last_data == 9'h03C, "R2 frame 3C", last_data, 9'h03C);

        // R2: inverted level
        set_mode(1'b0, 1'b1, 1'b0);
        send_frame(9'h05A, 1'b1, 3);
        chk(last_data == 9'h05A, "R2 inverted", last_data, 9'h05A);

        // R6: nine-bit frame
        set_mode(1'b0, 1'b0, 1'b1);
        send_frame(9'h1C3, 1'b1, 3);
        chk(last_data == 9'h1C3, "R6 nine-bit", last_data, 9'h1C3);

        // R7: framing error, data still delivered
        set_mode(1'b0, 1'b0, 1'b0);
        nv = n_valid;
        send_frame(9'h081, 1'b0, 3);
        chk(n_valid == nv + 1 && last_ferr && last_data == 9'h081, "R7 ferr frame", {last_ferr, last_data}, {1'b1, 9'h081});
        send_idle(12);

        // R8: false start, then R9 idle clears active
        nv = n_valid;
        send_bit(1'b1, 16'h0007, 3);
        chk(active == 1'b1, "R5 set on RT1", active, 1);
        send_idle(11);
        chk(n_valid == nv, "R8 false start", n_valid, nv);
        chk(active == 1'b0, "R9 active cleared", active, 0);

        // R4: majority vote ignores off-centre noise, tolerates one centre error
        send_bit(1'b0, 16'h0000, 3);
        send_bit(1'b1, 16'hFC7F, 3);
        send_bit(1'b0, 16'h0100, 3);
        for (int k = 0; k < 6; k++) send_bit(1'b1, 16'h0200, 3);
        send_bit(1'b1, 16'h0000, 3);
        send_bit(1'b1, 16'h0000, 3);
        send_idle(2);
        chk(last_data == 9'h0FD, "R4 majority", last_data, 9'h0FD);

        // R3: pulse mode, normal and inverted, including a one-tick pulse
        set_mode(1'b1, 1'b0, 1'b0);
        send_idle(2);
        send_frame(9'h096, 1'b1, 3);
        chk(last_data == 9'h096, "R3 pulse normal", last_data, 9'h096);
        set_mode(1'b1, 1'b1, 1'b0);
        send_idle(2);
        send_frame(9'h069, 1'b1, 3);
        chk(last_data == 9'h069, "R3 pulse inverted", last_data, 9'h069);
        send_frame(9'h0E2, 1'b1, 1);
        chk(last_data == 9'h0E2, "R3 one-tick pulse", last_data, 9'h0E2);

        // R10: no tick, nothing moves
        nv = n_valid;
        repeat (20) @(negedge clk);
        chk(n_valid == nv && !idle, "R10 no tick", n_valid, nv);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule